// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block is the coherence and bookkeeping half of one processor's private cache in a four-processor system. The cache is direct-mapped and holds only tags and a three-valued line state: invalid, shared or modified. Data is not stored here. A local request carries a word address and a read/write flag. The controller answers one cycle later with hit or miss. On a miss it places a one-cycle request on the shared bus. The request carries the miss kind, its own processor number and the line address.

The controller also snoops the misses that the other three processors broadcast. A remote read miss demotes an owned line to shared. A remote write miss drops a matching line to invalid. Each line remembers whether remote traffic lowered it since its last local access. When a local access then misses on a line whose tag still matches, the miss is classified as a coherence miss.

Seven saturating counters track read hits, write hits, read misses, write misses, total hits, total misses and coherence misses. They give a running profile of the sharing behaviour of the processor.

Top module: `msi_snoop_cache`

## Requirements
- R1: With 4-word lines and 128 lines, the line index is bits [8:2] of the word address and the tag is bits [15:9]. Two addresses with the same index and different tags evict each other. For example, address 2053 displaces the line holding address 5, so the next read of 5 misses.
- R2: A local read of an invalid or non-matching line is a read miss and leaves the line shared with the new tag. A read of a shared or modified matching line is a hit and keeps its state.
- R3: A local write to a modified matching line is a write hit. Any other local write, including one to a shared matching line, is a write miss. After any local write the line is modified.
- R4: A remote read miss whose line address matches a resident line demotes modified to shared. It leaves shared and invalid lines unchanged.
- R5: A remote write miss whose line address matches a resident line makes a shared or modified line invalid.
- R6: Snoop requests that carry this cache's own processor number are ignored. Snoop requests whose tag differs from the resident tag at that index are also ignored.
- R7: Each local miss raises `bus_valid` for exactly the one cycle after the request. At that time `bus_write` gives the miss kind (1 = write miss), `bus_id` equals `CPU_ID`, and `bus_line` is the word address shifted right by 2. Hits and snoops raise nothing.
- R8: `resp_valid` is high exactly in the cycle after each accepted request, with `resp_hit` and `resp_coh` valid at that time.
- R9: The read-hit, write-hit, read-miss and write-miss counters each count their own outcome. The hit and miss totals count every hit and every miss. All counters read zero after a synchronous reset, and snoop traffic alone leaves every counter unchanged.
- R10: A local miss is a coherence miss (`resp_coh` = 1, coherence counter +1) when the tag still matches and remote traffic lowered the line since its last local access. Any local access to a line clears this mark.
- R11: Every counter stops at its all-ones value instead of wrapping.
- R12: If a local request and an accepted snoop target the same line in the same cycle, the local access is applied first and the snoop then acts on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Local request present this cycle |
| req_write | input | 1 | 1 = local write, 0 = local read |
| req_addr | input | ADDR_W | Word address of the local request |
| snoop_valid | input | 1 | A bus miss is visible this cycle |
| snoop_write | input | 1 | 1 = remote write miss, 0 = remote read miss |
| snoop_id | input | ID_W | Processor that issued the bus miss |
| snoop_line | input | ADDR_W-2 | Line address of the bus miss |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_hit | output | 1 | The request hit |
| resp_coh | output | 1 | The miss was a coherence miss |
| bus_valid | output | 1 | Outgoing miss request |
| bus_write | output | 1 | Outgoing miss kind, 1 = write miss |
| bus_id | output | ID_W | This cache's processor number |
| bus_line | output | ADDR_W-2 | Line address of the outgoing miss |
| cnt_read_hit | output | CNT_W | Read hits |
| cnt_write_hit | output | CNT_W | Write hits |
| cnt_read_miss | output | CNT_W | Read misses |
| cnt_write_miss | output | CNT_W | Write misses |
| cnt_hit | output | CNT_W | All hits |
| cnt_miss | output | CNT_W | All misses |
| cnt_coh_miss | output | CNT_W | Coherence misses |

## Verification
The assertions check the following on every cycle. Each line's state moves correctly under an isolated local read fill, a local write, a remote read and a remote write. Counters only step by one, hold when idle and stick at their maximum. Snoop-only cycles leave the hit and miss totals alone. A coherence flag never comes with a hit.

Some behaviour needs ordered histories, and only the bench's scenarios can show it. These are conflict eviction between tags, a coherence mark cleared by an intervening local hit, the treatment of the own-ID and wrong-tag snoops, and a local access and a snoop colliding on one line. The same applies to the exact counter totals after mixed streams.

// File: rtl/msi_cache_pkg.sv
package msi_cache_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_MOD = 2'd2
   } line_state_e;

   // State a line takes after a local access.
   function automatic line_state_e local_next(line_state_e cur, logic tag_eq, logic wr);
      if (wr)
         return LN_MOD;
      else if (tag_eq && cur != LN_INV)
         return cur;
      else
         return LN_SHR;
   endfunction

   // State a matching line takes when another processor misses on it.
   function automatic line_state_e remote_next(line_state_e cur, logic wr);
      if (wr)
         return LN_INV;
      else if (cur == LN_MOD)
         return LN_SHR;
      else
         return cur;
   endfunction

   // True when a remote miss lowers the line's permission.
   function automatic logic remote_lowers(line_state_e cur, logic wr);
      if (wr)
         return cur != LN_INV;
      else
         return cur == LN_MOD;
   endfunction

   // Indices of the statistics counters.
   localparam int ST_RD_HIT  = 0;
   localparam int ST_WR_HIT  = 1;
   localparam int ST_RD_MISS = 2;
   localparam int ST_WR_MISS = 3;
   localparam int ST_HIT     = 4;
   localparam int ST_MISS    = 5;
   localparam int ST_COH     = 6;
   localparam int ST_COUNT   = 7;

endpackage

// File: rtl/msi_line.sv
module msi_line
   import msi_cache_pkg::*;
#(
   parameter int TAG_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             loc_sel,
   input  logic             loc_wr,
   input  logic [TAG_W-1:0] loc_tag,
   input  logic             snp_sel,
   input  logic             snp_wr,
   input  logic [TAG_W-1:0] snp_tag,
   output logic [TAG_W-1:0] tag_o,
   output line_state_e      state_o,
   output logic             lost_o
);

   logic [TAG_W-1:0] tag_q, mid_tag;
   line_state_e      state_q, mid_state, nxt_state;
   logic             lost_q, mid_lost, nxt_lost;
   logic             snp_match;

   // Local access first, then the snoop acts on its result (R12).
   always_comb begin
      if (loc_sel) begin
         mid_tag   = loc_tag;
         mid_state = local_next(state_q, tag_q == loc_tag, loc_wr);
         mid_lost  = 1'b0;
      end else begin
         mid_tag   = tag_q;
         mid_state = state_q;
         mid_lost  = lost_q;
      end
      snp_match = snp_sel && (mid_tag == snp_tag);
      nxt_state = snp_match ? remote_next(mid_state, snp_wr) : mid_state;
      nxt_lost  = mid_lost | (snp_match && remote_lowers(mid_state, snp_wr));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tag_q   <= '0;
         state_q <= LN_INV;
         lost_q  <= 1'b0;
      end else begin
         tag_q   <= mid_tag;
         state_q <= nxt_state;
         lost_q  <= nxt_lost;
      end
   end

   assign tag_o   = tag_q;
   assign state_o = state_q;
   assign lost_o  = lost_q;

   p_read_fill_r2: assert property (@(posedge clk) disable iff (rst)
      loc_sel && !loc_wr && !snp_sel && state_q == LN_INV |=> state_q == LN_SHR);

   p_write_owns_r3: assert property (@(posedge clk) disable iff (rst)
      loc_sel && loc_wr && !snp_sel |=> state_q == LN_MOD);

   p_remote_rd_down_r4: assert property (@(posedge clk) disable iff (rst)
      snp_sel && !snp_wr && !loc_sel && tag_q == snp_tag && state_q == LN_MOD
      |=> state_q == LN_SHR && lost_q);

   p_remote_wr_inval_r5: assert property (@(posedge clk) disable iff (rst)
      snp_sel && snp_wr && !loc_sel && tag_q == snp_tag |=> state_q == LN_INV);

endmodule

// File: rtl/msi_line_array.sv
module msi_line_array
   import msi_cache_pkg::*;
#(
   parameter int LINES = 128,
   parameter int TAG_W = 7,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             loc_en,
   input  logic             loc_wr,
   input  logic [IDX_W-1:0] loc_idx,
   input  logic [TAG_W-1:0] loc_tag,
   input  logic             snp_en,
   input  logic             snp_wr,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic [TAG_W-1:0] snp_tag,
   output logic [TAG_W-1:0] rd_tag,
   output line_state_e      rd_state,
   output logic             rd_lost
);

   logic [TAG_W-1:0] tags   [LINES];
   line_state_e      states [LINES];
   logic             losts  [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      msi_line #(.TAG_W(TAG_W)) u_line (
         .clk     (clk),
         .rst     (rst),
         .loc_sel (loc_en && loc_idx == IDX_W'(i)),
         .loc_wr  (loc_wr),
         .loc_tag (loc_tag),
         .snp_sel (snp_en && snp_idx == IDX_W'(i)),
         .snp_wr  (snp_wr),
         .snp_tag (snp_tag),
         .tag_o   (tags[i]),
         .state_o (states[i]),
         .lost_o  (losts[i])
      );
   end

   assign rd_tag   = tags[loc_idx];
   assign rd_state = states[loc_idx];
   assign rd_lost  = losts[loc_idx];

endmodule

// File: rtl/msi_sat_counter.sv
module msi_sat_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (inc && count != TOP)
         count <= count + 1'b1;
   end

   p_sat_hold_r11: assert property (@(posedge clk) disable iff (rst)
      inc && count == TOP |=> count == TOP);

   p_step_one_r9: assert property (@(posedge clk) disable iff (rst)
      inc && count != TOP |=> count == $past(count) + 1'b1);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(count));

endmodule

// File: rtl/msi_stats.sv
module msi_stats
   import msi_cache_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ev_valid,
   input  logic             ev_wr,
   input  logic             ev_hit,
   input  logic             ev_coh,
   output logic [CNT_W-1:0] counts [ST_COUNT]
);

   logic [ST_COUNT-1:0] inc;

   always_comb begin
      inc             = '0;
      inc[ST_RD_HIT]  = ev_valid && !ev_wr && ev_hit;
      inc[ST_WR_HIT]  = ev_valid && ev_wr && ev_hit;
      inc[ST_RD_MISS] = ev_valid && !ev_wr && !ev_hit;
      inc[ST_WR_MISS] = ev_valid && ev_wr && !ev_hit;
      inc[ST_HIT]     = ev_valid && ev_hit;
      inc[ST_MISS]    = ev_valid && !ev_hit;
      inc[ST_COH]     = ev_valid && !ev_hit && ev_coh;
   end

   for (genvar k = 0; k < ST_COUNT; k++) begin : g_cnt
      msi_sat_counter #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst   (rst),
         .inc   (inc[k]),
         .count (counts[k])
      );
   end

endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
   import msi_cache_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LINES      = 128,
   parameter int LINE_WORDS = 4,
   parameter int CNT_W      = 32,
   parameter int CPU_COUNT  = 4,
   parameter int ID_W       = 2,
   parameter int CPU_ID     = 0
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 req_valid,
   input  logic                                 req_write,
   input  logic [ADDR_W-1:0]                    req_addr,
   input  logic                                 snoop_valid,
   input  logic                                 snoop_write,
   input  logic [ID_W-1:0]                      snoop_id,
   input  logic [ADDR_W-$clog2(LINE_WORDS)-1:0] snoop_line,
   output logic                                 resp_valid,
   output logic                                 resp_hit,
   output logic                                 resp_coh,
   output logic                                 bus_valid,
   output logic                                 bus_write,
   output logic [ID_W-1:0]                      bus_id,
   output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] bus_line,
   output logic [CNT_W-1:0]                     cnt_read_hit,
   output logic [CNT_W-1:0]                     cnt_write_hit,
   output logic [CNT_W-1:0]                     cnt_read_miss,
   output logic [CNT_W-1:0]                     cnt_write_miss,
   output logic [CNT_W-1:0]                     cnt_hit,
   output logic [CNT_W-1:0]                     cnt_miss,
   output logic [CNT_W-1:0]                     cnt_coh_miss
);

   localparam int OFF_W   = $clog2(LINE_WORDS);
   localparam int IDX_W   = $clog2(LINES);
   localparam int LINE_AW = ADDR_W - OFF_W;
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;

   // Elaboration-time parameter checks.
   if ((LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if ((LINE_WORDS & (LINE_WORDS - 1)) != 0 || LINE_WORDS < 2) begin : g_bad_words
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the chosen geometry");
   end
   if ((1 << ID_W) < CPU_COUNT || CPU_ID >= CPU_COUNT || CPU_ID < 0) begin : g_bad_id
      $error("ID_W or CPU_ID inconsistent with CPU_COUNT");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   // Address split of the local request (R1).
   logic [IDX_W-1:0]   req_idx;
   logic [TAG_W-1:0]   req_tag;
   logic [LINE_AW-1:0] req_line;
   assign req_line = req_addr[ADDR_W-1:OFF_W];
   assign req_idx  = req_line[IDX_W-1:0];
   assign req_tag  = req_line[LINE_AW-1:IDX_W];

   // Snoop filter (R6): drop the cache's own broadcasts.
   logic             snp_take;
   logic [IDX_W-1:0] snp_idx;
   logic [TAG_W-1:0] snp_tag;
   assign snp_take = snoop_valid && (snoop_id != ID_W'(CPU_ID));
   assign snp_idx  = snoop_line[IDX_W-1:0];
   assign snp_tag  = snoop_line[LINE_AW-1:IDX_W];

   logic [TAG_W-1:0] cur_tag;
   line_state_e      cur_state;
   logic             cur_lost;

   msi_line_array #(.LINES(LINES), .TAG_W(TAG_W)) u_array (
      .clk      (clk),
      .rst      (rst),
      .loc_en   (req_valid),
      .loc_wr   (req_write),
      .loc_idx  (req_idx),
      .loc_tag  (req_tag),
      .snp_en   (snp_take),
      .snp_wr   (snoop_write),
      .snp_idx  (snp_idx),
      .snp_tag  (snp_tag),
      .rd_tag   (cur_tag),
      .rd_state (cur_state),
      .rd_lost  (cur_lost)
   );

   // Hit/miss classification of the local request.
   logic tag_eq, is_hit, is_coh;
   always_comb begin
      tag_eq = (cur_tag == req_tag);
      if (req_write)
         is_hit = tag_eq && cur_state == LN_MOD;
      else
         is_hit = tag_eq && cur_state != LN_INV;
      is_coh = !is_hit && tag_eq && cur_lost;
   end

   // Response and bus request registers (R7, R8).
   always_ff @(posedge clk) begin
      if (rst) begin
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_coh   <= 1'b0;
         bus_valid  <= 1'b0;
         bus_write  <= 1'b0;
         bus_line   <= '0;
      end else begin
         resp_valid <= req_valid;
         resp_hit   <= req_valid && is_hit;
         resp_coh   <= req_valid && is_coh;
         bus_valid  <= req_valid && !is_hit;
         bus_write  <= req_write;
         bus_line   <= req_line;
      end
   end

   assign bus_id = ID_W'(CPU_ID);

   logic [CNT_W-1:0] counts [ST_COUNT];

   msi_stats #(.CNT_W(CNT_W)) u_stats (
      .clk      (clk),
      .rst      (rst),
      .ev_valid (req_valid),
      .ev_wr    (req_write),
      .ev_hit   (is_hit),
      .ev_coh   (is_coh),
      .counts   (counts)
   );

   assign cnt_read_hit   = counts[ST_RD_HIT];
   assign cnt_write_hit  = counts[ST_WR_HIT];
   assign cnt_read_miss  = counts[ST_RD_MISS];
   assign cnt_write_miss = counts[ST_WR_MISS];
   assign cnt_hit        = counts[ST_HIT];
   assign cnt_miss       = counts[ST_MISS];
   assign cnt_coh_miss   = counts[ST_COH];

   p_coh_is_miss_r10: assert property (@(posedge clk) disable iff (rst)
      resp_valid && resp_coh |-> !resp_hit && bus_valid);

   p_remote_no_count_r9: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> $stable(cnt_hit) && $stable(cnt_miss) && $stable(cnt_coh_miss));

   p_bus_follows_miss_r7: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> bus_valid == !resp_hit);

endmodule

// File: tb/msi_snoop_cache_test.sv
module msi_snoop_cache_test;

   typedef struct packed {
      logic [1:0]  kind;   // 0 local, 1 snoop, 2 reset
      logic        wr;
      logic [15:0] addr;   // word address, or line address for a snoop
      logic [1:0]  id;
      logic        hit;
      logic        coh;
   } vec_t;

   localparam logic [1:0] K_LOC = 2'd0;
   localparam logic [1:0] K_SNP = 2'd1;
   localparam logic [1:0] K_RST = 2'd2;
   localparam int NV = 38;

   localparam vec_t TBL [NV] = '{
      // basic local transitions (R2, R3)
      '{K_LOC, 1'b0, 16'd0,    2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b1, 16'd4,    2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd1,    2'd0, 1'b1, 1'b0},
      '{K_LOC, 1'b1, 16'd2,    2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd0,    2'd0, 1'b1, 1'b0},
      '{K_LOC, 1'b1, 16'd0,    2'd0, 1'b1, 1'b0},
      '{K_RST, 1'b0, 16'd0,    2'd0, 1'b0, 1'b0},
      // mixed stream with a conflict eviction (R1)
      '{K_LOC, 1'b0, 16'd5,    2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b1, 16'd10,   2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd11,   2'd0, 1'b1, 1'b0},
      '{K_LOC, 1'b0, 16'd6,    2'd0, 1'b1, 1'b0},
      '{K_LOC, 1'b0, 16'd20,   2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b1, 16'd11,   2'd0, 1'b1, 1'b0},
      '{K_LOC, 1'b1, 16'd7,    2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd5,    2'd0, 1'b1, 1'b0},
      '{K_LOC, 1'b0, 16'd24,   2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b1, 16'd35,   2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b1, 16'd24,   2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd2053, 2'd0, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd5,    2'd0, 1'b0, 1'b0},
      '{K_RST, 1'b0, 16'd0,    2'd0, 1'b0, 1'b0},
      // remote influence and coherence misses (R4, R5, R10)
      '{K_SNP, 1'b0, 16'd0,    2'd1, 1'b0, 1'b0},
      '{K_SNP, 1'b1, 16'd0,    2'd1, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd4,    2'd0, 1'b0, 1'b0},
      '{K_SNP, 1'b0, 16'd1,    2'd1, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd4,    2'd0, 1'b1, 1'b0},
      '{K_SNP, 1'b1, 16'd1,    2'd1, 1'b0, 1'b0},
      '{K_LOC, 1'b1, 16'd6,    2'd0, 1'b0, 1'b1},
      '{K_SNP, 1'b0, 16'd1,    2'd1, 1'b0, 1'b0},
      '{K_LOC, 1'b1, 16'd4,    2'd0, 1'b0, 1'b1},
      '{K_SNP, 1'b0, 16'd1,    2'd1, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd4,    2'd0, 1'b1, 1'b0},
      '{K_LOC, 1'b1, 16'd5,    2'd0, 1'b0, 1'b0},
      '{K_SNP, 1'b1, 16'd1,    2'd1, 1'b0, 1'b0},
      '{K_LOC, 1'b0, 16'd6,    2'd0, 1'b0, 1'b1},
      '{K_LOC, 1'b1, 16'd7,    2'd0, 1'b0, 1'b0},
      '{K_SNP, 1'b1, 16'd1,    2'd1, 1'b0, 1'b0},
      '{K_LOC, 1'b1, 16'd4,    2'd0, 1'b0, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic        snoop_valid = 1'b0, snoop_write = 1'b0;
   logic [1:0]  snoop_id = '0;
   logic [13:0] snoop_line = '0;

   logic        resp_valid, resp_hit, resp_coh, bus_valid, bus_write;
   logic [1:0]  bus_id;
   logic [13:0] bus_line;
   logic [31:0] c_rh, c_wh, c_rm, c_wm, c_h, c_m, c_c;

   logic        s_rv, s_rh, s_rc, s_bv, s_bw;
   logic [1:0]  s_bid;
   logic [13:0] s_bl;
   logic [2:0]  s_rh3, s_wh3, s_rm3, s_wm3, s_h3, s_m3, s_c3;

   always #5 clk = ~clk;

   msi_snoop_cache uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .snoop_valid(snoop_valid), .snoop_write(snoop_write), .snoop_id(snoop_id),
      .snoop_line(snoop_line), .resp_valid(resp_valid), .resp_hit(resp_hit),
      .resp_coh(resp_coh), .bus_valid(bus_valid), .bus_write(bus_write), .bus_id(bus_id),
      .bus_line(bus_line), .cnt_read_hit(c_rh), .cnt_write_hit(c_wh), .cnt_read_miss(c_rm),
      .cnt_write_miss(c_wm), .cnt_hit(c_h), .cnt_miss(c_m), .cnt_coh_miss(c_c)
   );

   // Narrow-counter copy fed with the same stimulus, for saturation (R11).
   msi_snoop_cache #(.CNT_W(3)) uut_sat (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .snoop_valid(snoop_valid), .snoop_write(snoop_write), .snoop_id(snoop_id),
      .snoop_line(snoop_line), .resp_valid(s_rv), .resp_hit(s_rh), .resp_coh(s_rc),
      .bus_valid(s_bv), .bus_write(s_bw), .bus_id(s_bid), .bus_line(s_bl),
      .cnt_read_hit(s_rh3), .cnt_write_hit(s_wh3), .cnt_read_miss(s_rm3),
      .cnt_write_miss(s_wm3), .cnt_hit(s_h3), .cnt_miss(s_m3), .cnt_coh_miss(s_c3)
   );

   int checks = 0, failures = 0;
   int t_rh = 0, t_wh = 0, t_rm = 0, t_wm = 0, t_coh = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] sat7(input int v);
      return (v > 7) ? 32'd7 : 32'(v);
   endfunction

   task automatic check_counters(input string tag);
      chk({tag, " R9 read hits"},   c_rh, 32'(t_rh));
      chk({tag, " R9 write hits"},  c_wh, 32'(t_wh));
      chk({tag, " R9 read misses"}, c_rm, 32'(t_rm));
      chk({tag, " R9 write misses"},c_wm, 32'(t_wm));
      chk({tag, " R9 hit total"},   c_h,  32'(t_rh + t_wh));
      chk({tag, " R9 miss total"},  c_m,  32'(t_rm + t_wm));
      chk({tag, " R10 coh count"},  c_c,  32'(t_coh));
      chk({tag, " R11 sat hits"},   32'(s_h3), sat7(t_rh + t_wh));
      chk({tag, " R11 sat misses"}, 32'(s_m3), sat7(t_rm + t_wm));
      chk({tag, " R11 sat rd miss"},32'(s_rm3), sat7(t_rm));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      t_rh = 0; t_wh = 0; t_rm = 0; t_wm = 0; t_coh = 0;
      check_counters("reset");
      chk("R8 resp idle after reset", 32'(resp_valid), 32'd0);
      chk("R7 bus idle after reset",  32'(bus_valid),  32'd0);
   endtask

   task automatic tally(input logic wr, input logic hit, input logic coh);
      if (hit) begin
         if (wr) t_wh++; else t_rh++;
      end else begin
         if (wr) t_wm++; else t_rm++;
         if (coh) t_coh++;
      end
   endtask

   // Local access with optional same-cycle snoop; check one cycle later.
   task automatic do_local(input logic wr, input logic [15:0] addr, input logic ehit,
                           input logic ecoh, input logic with_snp, input logic swr,
                           input logic [1:0] sid, input logic [13:0] sline);
      string kind;
      kind = wr ? "R3 write" : "R2 read";
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr;
      snoop_valid = with_snp; snoop_write = swr; snoop_id = sid; snoop_line = sline;
      @(negedge clk);
      req_valid = 1'b0; snoop_valid = 1'b0;
      chk({kind, " R8 resp_valid"}, 32'(resp_valid), 32'd1);
      chk({kind, " hit"},           32'(resp_hit),   32'(ehit));
      chk({kind, " R10 coh flag"},  32'(resp_coh),   32'(ecoh));
      chk({kind, " R7 bus_valid"},  32'(bus_valid),  32'(!ehit));
      if (!ehit) begin
         chk("R7 bus_write", 32'(bus_write), 32'(wr));
         chk("R7 bus_id",    32'(bus_id),    32'd0);
         chk("R7 bus_line",  32'(bus_line),  32'(addr >> 2));
      end
      tally(wr, ehit, ecoh);
      @(negedge clk);
      chk("R7 bus pulse one cycle", 32'(bus_valid), 32'd0);
      chk("R8 resp pulse one cycle", 32'(resp_valid), 32'd0);
   endtask

   task automatic do_snoop(input logic wr, input logic [13:0] line, input logic [1:0] id);
      @(negedge clk);
      snoop_valid = 1'b1; snoop_write = wr; snoop_id = id; snoop_line = line;
      @(negedge clk);
      snoop_valid = 1'b0;
      chk("R7 no bus on snoop", 32'(bus_valid), 32'd0);
      chk("R8 no resp on snoop", 32'(resp_valid), 32'd0);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();

      // Table walk: R1..R5, R7..R10 through streamed vectors.
      for (int i = 0; i < NV; i++) begin
         case (TBL[i].kind)
            K_LOC: do_local(TBL[i].wr, TBL[i].addr, TBL[i].hit, TBL[i].coh,
                            1'b0, 1'b0, 2'd0, 14'd0);
            K_SNP: begin
               do_snoop(TBL[i].wr, TBL[i].addr[13:0], TBL[i].id);
               check_counters("snoop only");
            end
            default: begin
               check_counters("section end");
               do_reset();
            end
         endcase
      end
      check_counters("coherence section");

      // R6: own-ID snoop ignored; line 1 is modified with tag 0.
      do_snoop(1'b1, 14'd1, 2'd0);
      do_local(1'b0, 16'd4, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 14'd0);
      // R6 and R1: snoop on same index with another tag is ignored.
      do_snoop(1'b1, 14'd513, 2'd2);
      do_local(1'b1, 16'd4, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 14'd0);

      // R12: fill and remote write on the same line in the same cycle.
      do_local(1'b0, 16'd100, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 14'd25);
      do_local(1'b0, 16'd100, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 14'd0);

      // R4: remote read leaves a shared line usable; counters untouched (R9).
      do_snoop(1'b0, 14'd25, 2'd1);
      check_counters("R4 after remote read");
      do_local(1'b0, 16'd100, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 14'd0);

      // R11: conflicting reads at one index drive the narrow counters to the top.
      for (int k = 0; k < 5; k++)
         do_local(1'b0, 16'(3000 + 512 * k), 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 14'd0);
      check_counters("R11 saturation");
      chk("R11 narrow miss counter pinned", 32'(s_m3), 32'd7);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule